// File: doc/BRIEF.md
# Double-Buffered Multi-Channel DMA Sequencer

This block sequences memory-to-memory moves for several channels. Each channel keeps two register sets. The programmed set holds source, destination and byte count as software last wrote them. The active set drives the move in progress. While one move runs, software may load and enable a second one. When the running move finishes, the queued values are promoted into the active set and the channel keeps running with no idle visit in between.

A slow `tick` strobe drives a round-robin scheduler. Each tick serves exactly one channel. A served channel that is running does one of three things:
- it moves one burst of at most `BURST` bytes, announced on the `bst_*` outputs;
- it completes;
- it takes an armed fault.

Completion and fault raise sticky per-channel bits that software clears through a mask. A per-channel suppression counter can swallow one completion interrupt. Fault injection turns the next serve of a running channel into an error.

Scheduler FSM:
- `SCH_WAIT` goes to `SCH_SERVE` when `tick` is high.
- `SCH_SERVE` serves the pointed channel and returns to `SCH_WAIT`. If a command targets that channel in the same cycle, it holds for one cycle instead.

Channel FSM:
- `CH_IDLE` goes to `CH_BUSY` on enable, loading the active set from the programmed set.
- `CH_BUSY` goes to `CH_QUEUED` on enable. It goes to `CH_IDLE` on stop, on a fault, or on completion.
- `CH_QUEUED` goes to `CH_BUSY` on completion, which promotes the queued set. It goes to `CH_IDLE` on stop or on a fault.

Top module: `dbdma_top`

## Requirements
- R1: After reset every channel is idle, `rd_status` reads 0 for every channel, `done_vec`, `err_vec`, `miss_err` and `bst_valid` are 0, and the scheduler points at channel 0.
- R2: Command ENABLE (`cmd_op`=1) on an idle channel copies the programmed source, destination and count into the active set and sets the run flag (`rd_status` bit 31).
- R3: ENABLE on a running channel sets only the pending flag (`rd_status` bit 30) and leaves the active set unchanged.
- R4: Serving a running channel whose active count is nonzero moves min(count, `BURST`) bytes. It pulses `bst_valid` with the channel, current source, current destination and that length. It lowers the count by that length and advances both addresses by it.
- R5: Each `tick` serves one channel, in the order 0,1,2,3,0,… . Serving an idle channel changes nothing and gives no burst.
- R6: Serving a running channel whose count is zero while a transfer is pending loads the programmed set into the active set, clears the pending flag, and keeps the run flag set.
- R7: Serving a running channel whose count is zero with nothing pending clears the run flag.
- R8: Every completion (R6 or R7) sets the channel's bit in `done_vec`, except when its suppression counter is nonzero. In that case the counter decrements and no bit is set. Bits in `done_vec` and `err_vec` stay set until the matching bit of `done_clr`/`err_clr` is high.
- R9: Command MISS (`cmd_op`=4) with `cmd_cnt` equal to 1 on an idle channel loads the suppression counter with 1. Any other count, or a running channel, leaves the counter unchanged and raises `miss_err` for the next cycle.
- R10: Command STOP (`cmd_op`=2) clears both the run and the pending flags.
- R11: After command FAIL (`cmd_op`=3), the next serve of that channel while it runs clears the run flag, sets its `err_vec` bit, and moves no data. The active count is left as it was, and the fault is consumed.
- R12: A command addressed to the channel the scheduler is about to serve delays that serve by one cycle, so the command takes effect first.
- R13: Command PROG (`cmd_op`=0) writes only the programmed set. The active set of a running channel is not altered by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Service strobe, one channel served per strobe |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | 0 PROG, 1 ENABLE, 2 STOP, 3 FAIL, 4 MISS |
| cmd_chan | input | CHW | Target channel |
| cmd_src | input | AW | Source address for PROG |
| cmd_dst | input | AW | Destination address for PROG |
| cmd_cnt | input | CW | Byte count for PROG, requested miss count for MISS |
| done_clr | input | NCH | Clear mask for `done_vec` |
| err_clr | input | NCH | Clear mask for `err_vec` |
| rd_chan | input | CHW | Channel shown on the read port |
| rd_status | output | 32 | Bit 31 run, bit 30 pending, others 0 |
| rd_src | output | AW | Active source of `rd_chan` |
| rd_dst | output | AW | Active destination of `rd_chan` |
| rd_cnt | output | CW | Active count of `rd_chan` |
| done_vec | output | NCH | Sticky completion bits |
| err_vec | output | NCH | Sticky fault bits |
| miss_err | output | 1 | One-cycle refusal of a MISS command |
| bst_valid | output | 1 | Burst issued this cycle |
| bst_chan | output | CHW | Channel of the burst |
| bst_src | output | AW | Burst source address |
| bst_dst | output | AW | Burst destination address |
| bst_len | output | CW | Burst length in bytes |

## Verification
The bench builds the block with its defaults: four channels, 32-bit addresses, a 13-bit count and a 2048-byte burst. With these values a full count of 8191 splits into three full bursts and a 2047-byte tail, and counts just below, at and above one burst are all reachable. Four channels keep a full round-robin lap short, so the bench can watch an idle channel being skipped between two active ones. It can also place a command in the very cycle a channel's serve is due.

// File: rtl/dbdma_pkg.sv
package dbdma_pkg;

    typedef enum logic [2:0] {
        OP_PROG   = 3'd0,
        OP_ENABLE = 3'd1,
        OP_STOP   = 3'd2,
        OP_FAIL   = 3'd3,
        OP_MISS   = 3'd4
    } dma_op_t;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_BUSY   = 2'd1,
        CH_QUEUED = 2'd2
    } ch_state_t;

    typedef enum logic {
        SCH_WAIT  = 1'b0,
        SCH_SERVE = 1'b1
    } sch_state_t;

    localparam int STAT_W        = 32;
    localparam int STAT_RUN_BIT  = 31;
    localparam int STAT_PEND_BIT = 30;

endpackage

// File: rtl/dbdma_sched.sv
module dbdma_sched
    import dbdma_pkg::*;
#(
    parameter int NCH = 4,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic           hold,
    output logic           visit,
    output logic [CHW-1:0] cur
);

    sch_state_t state_q, state_d;
    logic [CHW-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SCH_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SCH_WAIT:  if (tick)  state_d = SCH_SERVE;
            SCH_SERVE: if (!hold) state_d = SCH_WAIT;
        endcase
    end

    always_comb begin
        visit = (state_q == SCH_SERVE) && !hold;
        cur   = ptr_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (visit)
            ptr_q <= (ptr_q == CHW'(NCH - 1)) ? '0 : ptr_q + 1'b1;
    end

    // R5: a serve always returns the scheduler to waiting for the next tick
    a_r5_one_serve_per_tick: assert property (@(posedge clk) disable iff (!rst_n)
        visit |=> (state_q == SCH_WAIT));

    // R12: a hold keeps the pointer in place
    a_r12_hold_keeps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SCH_SERVE && hold) |=> $stable(ptr_q));

endmodule

// File: rtl/dbdma_chan.sv
module dbdma_chan
    import dbdma_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 13,
    parameter int BURST      = 2048,
    parameter int MISS_LIMIT = 1,
    localparam int MW = $clog2(MISS_LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_we,
    input  logic          en,
    input  logic          stop,
    input  logic          fail_set,
    input  logic          miss_set,
    input  logic [AW-1:0] w_src,
    input  logic [AW-1:0] w_dst,
    input  logic [CW-1:0] w_cnt,
    input  logic          visit,
    output logic          run,
    output logic          pend,
    output logic [AW-1:0] act_src,
    output logic [AW-1:0] act_dst,
    output logic [CW-1:0] act_cnt,
    output logic          bst_fire,
    output logic [CW-1:0] bst_len,
    output logic          done_pulse,
    output logic          err_pulse
);

    localparam logic [CW-1:0] BURST_C = CW'(BURST);

    ch_state_t state_q, state_d;

    logic [AW-1:0] prg_src, prg_dst;
    logic [CW-1:0] prg_cnt;
    logic          fail_armed;
    logic [MW-1:0] miss_cnt;
    logic          at_end, fault, cmpl;

    // Per-visit decisions
    always_comb begin
        run        = (state_q != CH_IDLE);
        pend       = (state_q == CH_QUEUED);
        at_end     = (act_cnt == '0);
        fault      = visit && run && fail_armed;
        cmpl       = visit && run && !fail_armed && at_end;
        bst_fire   = visit && run && !fail_armed && !at_end;
        bst_len    = (act_cnt > BURST_C) ? BURST_C : act_cnt;
        done_pulse = cmpl && (miss_cnt == '0);
        err_pulse  = fault;
    end

    // Channel state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // Channel transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (en) state_d = CH_BUSY;
            end
            CH_BUSY: begin
                if (stop)       state_d = CH_IDLE;
                else if (en)    state_d = CH_QUEUED;
                else if (fault) state_d = CH_IDLE;
                else if (cmpl)  state_d = CH_IDLE;
            end
            CH_QUEUED: begin
                if (stop)       state_d = CH_IDLE;
                else if (fault) state_d = CH_IDLE;
                else if (cmpl)  state_d = CH_BUSY;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Programmed (shadow) set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prg_src <= '0;
            prg_dst <= '0;
            prg_cnt <= '0;
        end else if (prog_we) begin
            prg_src <= w_src;
            prg_dst <= w_dst;
            prg_cnt <= w_cnt;
        end
    end

    // Active set: load on start, advance on burst, promote on queued completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_src <= '0;
            act_dst <= '0;
            act_cnt <= '0;
        end else if (state_q == CH_IDLE && en) begin
            act_src <= prg_src;
            act_dst <= prg_dst;
            act_cnt <= prg_cnt;
        end else if (bst_fire) begin
            act_src <= act_src + AW'(bst_len);
            act_dst <= act_dst + AW'(bst_len);
            act_cnt <= act_cnt - bst_len;
        end else if (cmpl && state_q == CH_QUEUED) begin
            act_src <= prg_src;
            act_dst <= prg_dst;
            act_cnt <= prg_cnt;
        end
    end

    // Fault injection and interrupt suppression
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_armed <= 1'b0;
            miss_cnt   <= '0;
        end else begin
            if (fail_set)   fail_armed <= 1'b1;
            else if (fault) fail_armed <= 1'b0;
            if (miss_set)                      miss_cnt <= MW'(MISS_LIMIT);
            else if (cmpl && miss_cnt != '0)   miss_cnt <= miss_cnt - 1'b1;
        end
    end

    // R3: enabling a running channel leaves the active set alone
    a_r3_active_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (en && run) |=> ($stable(act_src) && $stable(act_cnt)));

    // R4: a burst is never empty and never above the burst limit
    a_r4_burst_bound: assert property (@(posedge clk) disable iff (!rst_n)
        bst_fire |-> (bst_len != '0 && bst_len <= BURST_C));

    // R6: a completion with a queued set keeps the channel running
    a_r6_promote_runs: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && pend && at_end && !fail_armed) |=> (run && !pend));

    // R7: a completion with nothing queued stops the channel
    a_r7_end_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (visit && run && !pend && at_end && !fail_armed) |=> !run);

    // R10: stop clears both flags
    a_r10_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        stop |=> (!run && !pend));

    // R11: a fault moves no data
    a_r11_fault_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> ($stable(act_cnt) && !run));

    // R12: a serve and a command never reach the channel together
    a_r12_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
        visit |-> !(prog_we || en || stop || fail_set || miss_set));

endmodule

// File: rtl/dbdma_top.sv
module dbdma_top
    import dbdma_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int AW         = 32,
    parameter int CW         = 13,
    parameter int BURST      = 2048,
    parameter int MISS_LIMIT = 1,
    localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [CHW-1:0]    cmd_chan,
    input  logic [AW-1:0]     cmd_src,
    input  logic [AW-1:0]     cmd_dst,
    input  logic [CW-1:0]     cmd_cnt,
    input  logic [NCH-1:0]    done_clr,
    input  logic [NCH-1:0]    err_clr,
    input  logic [CHW-1:0]    rd_chan,
    output logic [STAT_W-1:0] rd_status,
    output logic [AW-1:0]     rd_src,
    output logic [AW-1:0]     rd_dst,
    output logic [CW-1:0]     rd_cnt,
    output logic [NCH-1:0]    done_vec,
    output logic [NCH-1:0]    err_vec,
    output logic              miss_err,
    output logic              bst_valid,
    output logic [CHW-1:0]    bst_chan,
    output logic [AW-1:0]     bst_src,
    output logic [AW-1:0]     bst_dst,
    output logic [CW-1:0]     bst_len
);

    logic           visit;
    logic [CHW-1:0] cur;
    logic           hold;

    logic [NCH-1:0] ch_run, ch_pend, ch_fire, ch_done, ch_err;
    logic [AW-1:0]  ch_src [NCH];
    logic [AW-1:0]  ch_dst [NCH];
    logic [CW-1:0]  ch_cnt [NCH];
    logic [CW-1:0]  ch_len [NCH];

    logic miss_req, miss_ok;

    always_comb begin
        hold     = cmd_valid && (cmd_chan == cur);
        miss_req = cmd_valid && (cmd_op == OP_MISS);
        miss_ok  = (cmd_cnt == CW'(MISS_LIMIT)) && !ch_run[cmd_chan];
    end

    dbdma_sched #(.NCH(NCH)) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .hold  (hold),
        .visit (visit),
        .cur   (cur)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        logic hit;
        assign hit = cmd_valid && (cmd_chan == CHW'(i));

        dbdma_chan #(
            .AW(AW), .CW(CW), .BURST(BURST), .MISS_LIMIT(MISS_LIMIT)
        ) u_chan (
            .clk        (clk),
            .rst_n      (rst_n),
            .prog_we    (hit && cmd_op == OP_PROG),
            .en         (hit && cmd_op == OP_ENABLE),
            .stop       (hit && cmd_op == OP_STOP),
            .fail_set   (hit && cmd_op == OP_FAIL),
            .miss_set   (hit && cmd_op == OP_MISS && miss_ok),
            .w_src      (cmd_src),
            .w_dst      (cmd_dst),
            .w_cnt      (cmd_cnt),
            .visit      (visit && cur == CHW'(i)),
            .run        (ch_run[i]),
            .pend       (ch_pend[i]),
            .act_src    (ch_src[i]),
            .act_dst    (ch_dst[i]),
            .act_cnt    (ch_cnt[i]),
            .bst_fire   (ch_fire[i]),
            .bst_len    (ch_len[i]),
            .done_pulse (ch_done[i]),
            .err_pulse  (ch_err[i])
        );
    end

    // Read port
    always_comb begin
        rd_status                = '0;
        rd_status[STAT_RUN_BIT]  = ch_run[rd_chan];
        rd_status[STAT_PEND_BIT] = ch_pend[rd_chan];
        rd_src                   = ch_src[rd_chan];
        rd_dst                   = ch_dst[rd_chan];
        rd_cnt                   = ch_cnt[rd_chan];
    end

    // Sticky vectors, burst announcement and miss refusal
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_vec  <= '0;
            err_vec   <= '0;
            miss_err  <= 1'b0;
            bst_valid <= 1'b0;
            bst_chan  <= '0;
            bst_src   <= '0;
            bst_dst   <= '0;
            bst_len   <= '0;
        end else begin
            done_vec  <= (done_vec & ~done_clr) | ch_done;
            err_vec   <= (err_vec & ~err_clr) | ch_err;
            miss_err  <= miss_req && !miss_ok;
            bst_valid <= ch_fire[cur];
            if (ch_fire[cur]) begin
                bst_chan <= cur;
                bst_src  <= ch_src[cur];
                bst_dst  <= ch_dst[cur];
                bst_len  <= ch_len[cur];
            end
        end
    end

    // R8: a completion bit survives until its clear bit is seen
    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_vec & ~done_clr) != '0) |=>
            ((done_vec & $past(done_vec & ~done_clr)) == $past(done_vec & ~done_clr)));

    // R9: a suppression request against a running channel is always refused
    a_r9_refuse_running: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_MISS && ch_run[cmd_chan]) |=> miss_err);

    // R5: at most one channel is served per cycle
    a_r5_single_burst: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_fire | ch_done | ch_err));

endmodule

// File: tb/tb_dbdma_top.sv
module tb_dbdma_top;

    localparam int NCH = 4, AW = 32, CW = 13, CHW = 2;
    localparam logic [2:0] PROG = 3'd0, ENA = 3'd1, STOP = 3'd2, FAIL = 3'd3, MISS = 3'd4;

    // {count, expected bursts, expected length of last burst}
    localparam logic [29:0] VEC [7] = '{
        {13'd0,    4'd0, 13'd0},
        {13'd1,    4'd1, 13'd1},
        {13'd2047, 4'd1, 13'd2047},
        {13'd2048, 4'd1, 13'd2048},
        {13'd2049, 4'd2, 13'd1},
        {13'd6000, 4'd3, 13'd1904},
        {13'd8191, 4'd4, 13'd2047}
    };

    logic clk = 0, rst_n = 0, tick = 0, cmd_valid = 0;
    logic [2:0] cmd_op = 0;
    logic [CHW-1:0] cmd_chan = 0, rd_chan = 0, bst_chan;
    logic [AW-1:0] cmd_src = 0, cmd_dst = 0, rd_src, rd_dst, bst_src, bst_dst;
    logic [CW-1:0] cmd_cnt = 0, rd_cnt, bst_len;
    logic [NCH-1:0] done_clr = 0, err_clr = 0, done_vec, err_vec;
    logic [31:0] rd_status;
    logic miss_err, bst_valid;

    int checks = 0, failures = 0, bptr = 0;

    always #2 clk = ~clk;

    dbdma_top dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_chan(cmd_chan), .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_cnt(cmd_cnt),
        .done_clr(done_clr), .err_clr(err_clr), .rd_chan(rd_chan), .rd_status(rd_status),
        .rd_src(rd_src), .rd_dst(rd_dst), .rd_cnt(rd_cnt), .done_vec(done_vec),
        .err_vec(err_vec), .miss_err(miss_err), .bst_valid(bst_valid), .bst_chan(bst_chan),
        .bst_src(bst_src), .bst_dst(bst_dst), .bst_len(bst_len)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [2:0] op, input int ch, input logic [AW-1:0] s,
                       input logic [AW-1:0] d, input logic [CW-1:0] n);
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_chan = CHW'(ch);
        cmd_src = s; cmd_dst = d; cmd_cnt = n;
        @(negedge clk);
        cmd_valid = 0;
    endtask

    task automatic rd(input int ch);
        rd_chan = CHW'(ch);
        #1;
    endtask

    task automatic do_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        @(negedge clk);
        bptr = (bptr + 1) % NCH;
    endtask

    task automatic visit(input int ch);
        while (bptr != ch) do_tick();
        do_tick();
    endtask

    task automatic clear_all();
        @(negedge clk); done_clr = '1; err_clr = '1;
        @(negedge clk); done_clr = '0; err_clr = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1: reset state
        for (int c = 0; c < NCH; c++) begin
            rd(c);
            chk("R1 status", rd_status, 32'h0);
        end
        chk("R1 done", 32'(done_vec), 0);
        chk("R1 err", 32'(err_vec), 0);
        chk("R1 burst", 32'(bst_valid), 0);
        chk("R1 miss_err", 32'(miss_err), 0);

        // R4 R7: table of counts on channel 0
        for (int v = 0; v < 7; v++) begin
            logic [CW-1:0] n;
            int nb, rem;
            n = VEC[v][29:17];
            nb = int'(VEC[v][16:13]);
            rem = int'(n);
            cmd(PROG, 0, 32'h1000_0000, 32'h2000_0000, n);
            cmd(ENA, 0, 0, 0, 0);
            for (int b = 0; b < nb; b++) begin
                int exp_len;
                exp_len = (rem > 2048) ? 2048 : rem;
                if (b == nb - 1) chk("R4 last len", 32'(exp_len), 32'(VEC[v][12:0]));
                visit(0);
                chk("R4 burst valid", 32'(bst_valid), 1);
                chk("R4 burst len", 32'(bst_len), 32'(exp_len));
                chk("R4 burst src", bst_src, 32'h1000_0000 + 32'(int'(n) - rem));
                rem -= exp_len;
            end
            visit(0);
            rd(0);
            chk("R7 run clear", rd_status, 0);
            chk("R7 cnt zero", 32'(rd_cnt), 0);
            chk("R4 src end", rd_src, 32'h1000_0000 + 32'(n));
            chk("R4 dst end", rd_dst, 32'h2000_0000 + 32'(n));
            chk("R8 done", 32'(done_vec), 32'h1);
            clear_all();
        end

        // R2 R3 R13 R6: double buffering on channel 1
        cmd(PROG, 1, 32'h100, 32'h900, 13'd100);
        cmd(ENA, 1, 0, 0, 0);
        rd(1);
        chk("R2 run", rd_status, 32'h8000_0000);
        chk("R2 src", rd_src, 32'h100);
        cmd(PROG, 1, 32'h400, 32'hA00, 13'd50);
        rd(1);
        chk("R13 active kept", rd_src, 32'h100);
        chk("R13 count kept", 32'(rd_cnt), 100);
        cmd(ENA, 1, 0, 0, 0);
        rd(1);
        chk("R3 pending", rd_status, 32'hC000_0000);
        chk("R3 count kept", 32'(rd_cnt), 100);
        visit(1);
        chk("R4 len 100", 32'(bst_len), 100);
        rd(1);
        chk("R4 src adv", rd_src, 32'h164);
        visit(1);
        chk("R6 no burst", 32'(bst_valid), 0);
        rd(1);
        chk("R6 still run", rd_status, 32'h8000_0000);
        chk("R6 promoted src", rd_src, 32'h400);
        chk("R6 promoted dst", rd_dst, 32'hA00);
        chk("R6 promoted cnt", 32'(rd_cnt), 50);
        chk("R8 done promote", 32'(done_vec), 32'h2);
        clear_all();
        visit(1);
        chk("R4 len 50", 32'(bst_len), 50);
        visit(1);
        rd(1);
        chk("R7 idle", rd_status, 0);
        chk("R8 done end", 32'(done_vec), 32'h2);
        clear_all();

        // R5: round robin skips idle channels
        while (bptr != 0) do_tick();
        cmd(PROG, 0, 32'h10, 32'h20, 13'd5);
        cmd(ENA, 0, 0, 0, 0);
        cmd(PROG, 3, 32'h30, 32'h40, 13'd7);
        cmd(ENA, 3, 0, 0, 0);
        do_tick();
        chk("R5 ch0 burst", {31'(bst_chan), bst_valid}, {31'd0, 1'b1});
        do_tick();
        chk("R5 ch1 idle", 32'(bst_valid), 0);
        do_tick();
        chk("R5 ch2 idle", 32'(bst_valid), 0);
        do_tick();
        chk("R5 ch3 burst", {31'(bst_chan), bst_valid}, {31'd3, 1'b1});
        chk("R5 ch3 len", 32'(bst_len), 7);
        visit(0); visit(3);
        chk("R5 both done", 32'(done_vec), 32'h9);
        clear_all();

        // R9 R8: interrupt suppression on channel 2
        cmd(MISS, 2, 0, 0, 13'd2);
        chk("R9 refuse 2", 32'(miss_err), 1);
        cmd(MISS, 2, 0, 0, 13'd0);
        chk("R9 refuse 0", 32'(miss_err), 1);
        cmd(MISS, 2, 0, 0, 13'd1);
        chk("R9 accept 1", 32'(miss_err), 0);
        cmd(PROG, 2, 32'h0, 32'h0, 13'd0);
        cmd(ENA, 2, 0, 0, 0);
        cmd(MISS, 2, 0, 0, 13'd1);
        chk("R9 refuse busy", 32'(miss_err), 1);
        visit(2);
        rd(2);
        chk("R8 missed irq", 32'(done_vec), 0);
        chk("R8 stopped", rd_status, 0);
        cmd(ENA, 2, 0, 0, 0);
        visit(2);
        chk("R9 counter not reloaded", 32'(done_vec), 32'h4);
        clear_all();

        // R10: stop clears run and pending
        cmd(PROG, 3, 32'h0, 32'h0, 13'd3000);
        cmd(ENA, 3, 0, 0, 0);
        cmd(ENA, 3, 0, 0, 0);
        rd(3);
        chk("R10 before", rd_status, 32'hC000_0000);
        cmd(STOP, 3, 0, 0, 0);
        rd(3);
        chk("R10 after", rd_status, 0);
        visit(3);
        chk("R10 no burst", 32'(bst_valid), 0);

        // R11: injected fault
        cmd(PROG, 0, 32'h500, 32'h600, 13'd500);
        cmd(FAIL, 0, 0, 0, 0);
        cmd(ENA, 0, 0, 0, 0);
        visit(0);
        rd(0);
        chk("R11 err bit", 32'(err_vec), 32'h1);
        chk("R11 no burst", 32'(bst_valid), 0);
        chk("R11 stopped", rd_status, 0);
        chk("R11 count kept", 32'(rd_cnt), 500);
        clear_all();
        chk("R8 err cleared", 32'(err_vec), 0);
        cmd(ENA, 0, 0, 0, 0);
        visit(0);
        chk("R11 fault consumed", 32'(bst_len), 500);
        visit(0);
        clear_all();

        // R12: command collides with the pending serve of channel 2
        cmd(PROG, 2, 32'h3000, 32'h4000, 13'd10);
        while (bptr != 2) do_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
        cmd_valid = 1; cmd_op = ENA; cmd_chan = 2'd2;
        @(negedge clk); cmd_valid = 0;
        chk("R12 deferred", 32'(bst_valid), 0);
        @(negedge clk);
        bptr = (bptr + 1) % NCH;
        chk("R12 served after cmd", {31'(bst_chan), bst_valid}, {31'd2, 1'b1});
        chk("R12 len", 32'(bst_len), 10);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule